// File: doc/BRIEF.md
# Character LCD Host Command Front End

This block sits between a host and the display memory of a character LCD controller. The host sends bytes over one of two links. One is an 8-bit parallel bus with chip select, a command/data select, write and read strobes. The other is an 8-bit serial link with chip select, command/data select, a shift clock, serial in and serial out. A strap input picks which link is live. Every byte that completes on the live link is marked as display data or as a command by the command/data select. Data bytes go to the display or blink plane at the current address pointer. Commands move the pointer, select the write plane, or perform fill steps that also advance the pointer.

Each accepted byte makes the block busy for a fixed number of source clocks. Bytes that complete while it is busy are dropped and recorded in a sticky overrun flag. A parallel read returns either the display byte at the pointer or a busy status byte, depending on the command/data select. The serial output reports busy, one bit per falling shift-clock edge. The memory itself sits outside the block and is reached through a write-strobe, address and data port with a combinational read return.

All strobes and the shift clock are sampled in the source clock domain through two-flop synchronizers.

Top module: `lcdHostFront`

## Requirements
- R1: With `serialMode` low only the parallel bus can deliver bytes. With it high only the serial link can. A transfer on the inactive link changes neither `ramAddr` nor any RAM strobe nor `busy`.
- R2: A parallel byte completes on the rising edge of `wrN` while `csN` is low. With `cmdSel` low it is written to the display plane (`ramWe`) at `ramAddr`, and the pointer then steps by one.
- R3: A serial byte is shifted in MSB first on rising `sclk` edges while `csN` is low, and completes on the 8th edge. `csN` high clears the bit count, so a partial frame is discarded.
- R4: While `serialMode` is high and `csN` is low, `sdo` takes the current busy state on each falling `sclk` edge. It reads 1 just after an accepted serial byte and 0 once idle.
- R5: With `serialMode` low, `dbOe` is high only while both `csN` and `rdN` are low. With `cmdSel` low, `dbOut` equals `ramRdata` at the pointer. With `cmdSel` high, `dbOut` is {7'b0, busy}.
- R6: After each accepted byte, `busy` is high for exactly BUSY_CYCLES (default 10) clock cycles, starting the cycle after acceptance.
- R7: A byte that completes while `busy` is high has no effect on RAM or the pointer. It sets `overrun`, which stays set until reset.
- R8: Command 8'b01aaaaaa loads the pointer with aaaaaa.
- R9: Command 8'h10 writes the blank code 8'h20 to the display plane, clears the blink bit at the pointer, and steps the pointer.
- R10: Command 8'h11 sets the blink bit (`ramWdata[0]`=1 with `ramBlinkWe`) at the pointer and steps the pointer.
- R11: Commands 8'h12 and 8'h13 route later data bytes to the display plane or to the blink plane. A blink-plane data write stores bit 0 of the byte and also steps the pointer. Any other command byte only starts the busy period.
- R12: The 6-bit pointer wraps from 63 to 0.
- R13: After reset the pointer is 0, the display plane is selected, and `busy`, `overrun`, `sdo` and `dbOe` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Source clock |
| rstN | input | 1 | Active-low synchronous reset |
| serialMode | input | 1 | Strap: 1 selects serial link, 0 parallel bus |
| csN | input | 1 | Active-low chip select (both links) |
| cmdSel | input | 1 | 1 = command, 0 = display data |
| wrN | input | 1 | Parallel write strobe, byte taken on rising edge |
| rdN | input | 1 | Parallel read strobe, active low |
| dbIn | input | 8 | Parallel data in |
| dbOut | output | 8 | Parallel data out |
| dbOe | output | 1 | Output enable for dbOut |
| sclk | input | 1 | Serial shift clock, idles high |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial busy out |
| busy | output | 1 | Busy after an accepted byte |
| overrun | output | 1 | Sticky: a byte was dropped while busy |
| ramWe | output | 1 | Display plane write strobe |
| ramBlinkWe | output | 1 | Blink plane write strobe (bit 0 of ramWdata) |
| ramAddr | output | 6 | Address pointer |
| ramWdata | output | 8 | Write data |
| ramRdata | input | 8 | Display byte read at ramAddr |

## Verification
Two events can fall in the same cycle: a byte completing on the bus and the busy window that an earlier byte opened. The bench provokes this by sending a second parallel write a few cycles after the first. It then checks that the display plane and the pointer hold only the first byte's effect and that the overrun flag is set. The length of the busy window is measured on its own at the falling clock edges. The bench also runs a serial frame that is cut short by chip select, followed by a full frame, to show that the partial bits never combine into a byte.

// File: rtl/lcdHostPkg.sv
package lcdHostPkg;

  localparam logic [7:0] CMD_AINC     = 8'h10;
  localparam logic [7:0] CMD_CHB      = 8'h11;
  localparam logic [7:0] CMD_TGT_DISP = 8'h12;
  localparam logic [7:0] CMD_TGT_BLNK = 8'h13;
  localparam logic [7:0] BLANK_CODE   = 8'h20;

  typedef struct packed {
    logic       dataWr;
    logic       cmdLoad;
    logic       cmdAinc;
    logic       cmdChb;
    logic       cmdTgtDisp;
    logic       cmdTgtBlink;
    logic [7:0] byteVal;
  } hostStrobe_t;

  function automatic logic isLoadCmd(input logic [7:0] b);
    return b[7:6] == 2'b01;
  endfunction

endpackage

// File: rtl/lcdHostCtrl.sv
module lcdHostCtrl
  import lcdHostPkg::*;
#(
  parameter int BUSY_CYCLES = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        serialMode,
  input  logic        csN,
  input  logic        cmdSel,
  input  logic        wrN,
  input  logic [7:0]  dbIn,
  input  logic        sclk,
  input  logic        sdi,
  output hostStrobe_t strb,
  output logic        busy,
  output logic        overrun,
  output logic        sdo
);

  localparam int CNT_W = $clog2(BUSY_CYCLES + 1);
  localparam int TOP   = SYNC_STAGES - 1;

  logic [TOP:0]     wrSync;
  logic [TOP:0]     sclkSync;
  logic [2:0]       bitCnt;
  logic [6:0]       shiftReg;
  logic [CNT_W-1:0] busyCnt;

  logic wrRise, sRise, sFall;
  logic parDone, serDone, byteDone, accept;
  logic [7:0] byteVal;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrSync   <= '1;
      sclkSync <= '1;
    end else begin
      wrSync   <= {wrSync[TOP-1:0], wrN};
      sclkSync <= {sclkSync[TOP-1:0], sclk};
    end
  end

  assign wrRise = wrSync[TOP-1] & ~wrSync[TOP];
  assign sRise  = sclkSync[TOP-1] & ~sclkSync[TOP];
  assign sFall  = ~sclkSync[TOP-1] & sclkSync[TOP];

  // serial shifter, MSB first
  always_ff @(posedge clk) begin
    if (!rstN) begin
      bitCnt   <= '0;
      shiftReg <= '0;
    end else if (csN || !serialMode) begin
      bitCnt <= '0;
    end else if (sRise) begin
      shiftReg <= {shiftReg[5:0], sdi};
      bitCnt   <= bitCnt + 3'd1;
    end
  end

  assign parDone  = !serialMode && !csN && wrRise;
  assign serDone  = serialMode && !csN && sRise && (bitCnt == 3'd7);
  assign byteDone = parDone || serDone;
  assign byteVal  = serialMode ? {shiftReg, sdi} : dbIn;
  assign accept   = byteDone && !busy;
  assign busy     = busyCnt != '0;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busyCnt <= '0;
      overrun <= 1'b0;
      sdo     <= 1'b0;
    end else begin
      if (accept)     busyCnt <= CNT_W'(BUSY_CYCLES);
      else if (busy)  busyCnt <= busyCnt - 1'b1;
      if (byteDone && busy) overrun <= 1'b1;
      if (serialMode && !csN && sFall) sdo <= busy;
    end
  end

  always_comb begin
    strb         = '0;
    strb.byteVal = byteVal;
    if (accept) begin
      if (!cmdSel) begin
        strb.dataWr = 1'b1;
      end else if (isLoadCmd(byteVal)) begin
        strb.cmdLoad = 1'b1;
      end else begin
        case (byteVal)
          CMD_AINC:     strb.cmdAinc     = 1'b1;
          CMD_CHB:      strb.cmdChb      = 1'b1;
          CMD_TGT_DISP: strb.cmdTgtDisp  = 1'b1;
          CMD_TGT_BLNK: strb.cmdTgtBlink = 1'b1;
          default:      ;
        endcase
      end
    end
  end

endmodule

// File: rtl/lcdHostData.sv
module lcdHostData
  import lcdHostPkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  hostStrobe_t       strb,
  input  logic              serialMode,
  input  logic              csN,
  input  logic              rdN,
  input  logic              cmdSel,
  input  logic              busy,
  input  logic [7:0]        ramRdata,
  output logic              ramWe,
  output logic              ramBlinkWe,
  output logic [ADDR_W-1:0] ramAddr,
  output logic [7:0]        ramWdata,
  output logic [7:0]        dbOut,
  output logic              dbOe
);

  logic [ADDR_W-1:0] ptr;
  logic              tgtBlink;
  logic              stepPtr;

  assign stepPtr = strb.dataWr || strb.cmdAinc || strb.cmdChb;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ptr      <= '0;
      tgtBlink <= 1'b0;
    end else begin
      if (strb.cmdLoad)     ptr <= strb.byteVal[ADDR_W-1:0];
      else if (stepPtr)     ptr <= ptr + 1'b1;
      if (strb.cmdTgtBlink) tgtBlink <= 1'b1;
      else if (strb.cmdTgtDisp) tgtBlink <= 1'b0;
    end
  end

  always_comb begin
    ramWe      = 1'b0;
    ramBlinkWe = 1'b0;
    ramWdata   = strb.byteVal;
    if (strb.dataWr) begin
      if (tgtBlink) begin
        ramBlinkWe = 1'b1;
        ramWdata   = {7'b0, strb.byteVal[0]};
      end else begin
        ramWe = 1'b1;
      end
    end
    if (strb.cmdAinc) begin
      ramWe      = 1'b1;
      ramBlinkWe = 1'b1;
      ramWdata   = BLANK_CODE;
    end
    if (strb.cmdChb) begin
      ramBlinkWe = 1'b1;
      ramWdata   = 8'h01;
    end
  end

  assign ramAddr = ptr;
  assign dbOe    = !serialMode && !csN && !rdN;
  assign dbOut   = cmdSel ? {7'b0, busy} : ramRdata;

endmodule

// File: rtl/lcdHostFront.sv
module lcdHostFront
  import lcdHostPkg::*;
#(
  parameter int ADDR_W      = 6,
  parameter int BUSY_CYCLES = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              serialMode,
  input  logic              csN,
  input  logic              cmdSel,
  input  logic              wrN,
  input  logic              rdN,
  input  logic [7:0]        dbIn,
  output logic [7:0]        dbOut,
  output logic              dbOe,
  input  logic              sclk,
  input  logic              sdi,
  output logic              sdo,
  output logic              busy,
  output logic              overrun,
  output logic              ramWe,
  output logic              ramBlinkWe,
  output logic [ADDR_W-1:0] ramAddr,
  output logic [7:0]        ramWdata,
  input  logic [7:0]        ramRdata
);

  hostStrobe_t strb;

  lcdHostCtrl #(
    .BUSY_CYCLES(BUSY_CYCLES),
    .SYNC_STAGES(SYNC_STAGES)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .serialMode(serialMode), .csN(csN),
    .cmdSel(cmdSel), .wrN(wrN), .dbIn(dbIn), .sclk(sclk), .sdi(sdi),
    .strb(strb), .busy(busy), .overrun(overrun), .sdo(sdo)
  );

  lcdHostData #(.ADDR_W(ADDR_W)) uData (
    .clk(clk), .rstN(rstN), .strb(strb), .serialMode(serialMode),
    .csN(csN), .rdN(rdN), .cmdSel(cmdSel), .busy(busy),
    .ramRdata(ramRdata), .ramWe(ramWe), .ramBlinkWe(ramBlinkWe),
    .ramAddr(ramAddr), .ramWdata(ramWdata), .dbOut(dbOut), .dbOe(dbOe)
  );

endmodule

// File: rtl/lcdHostFrontChk.sv
module lcdHostFrontChk #(
  parameter int ADDR_W      = 6,
  parameter int BUSY_CYCLES = 10
) (
  input logic              clk,
  input logic              rstN,
  input logic              busy,
  input logic              overrun,
  input logic              ramWe,
  input logic              ramBlinkWe,
  input logic [ADDR_W-1:0] ramAddr,
  input logic              dbOe,
  input logic              cmdSel,
  input logic [7:0]        dbOut
);

  localparam int RUN_W = $clog2(BUSY_CYCLES + 2) + 1;
  logic [RUN_W-1:0] runCnt;

  always_ff @(posedge clk) begin
    if (!rstN)     runCnt <= '0;
    else if (busy) runCnt <= runCnt + 1'b1;
    else           runCnt <= '0;
  end

  // R6: every strobe opens a busy window
  assert_busy_start_R6: assert property (@(posedge clk) disable iff (!rstN)
    (ramWe || ramBlinkWe) |=> busy);

  // R6: the window is exactly BUSY_CYCLES long
  assert_busy_len_R6: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && runCnt != '0) |-> (runCnt == RUN_W'(BUSY_CYCLES)));

  // R7: nothing reaches the RAM while busy
  assert_no_write_busy_R7: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !(ramWe || ramBlinkWe));

  // R7: overrun is sticky
  assert_overrun_sticky_R7: assert property (@(posedge clk) disable iff (!rstN)
    overrun |=> overrun);

  // R12: every RAM write steps the pointer by one, modulo its width
  assert_ptr_step_R12: assert property (@(posedge clk) disable iff (!rstN)
    (ramWe || ramBlinkWe) |=> ((ramAddr - $past(ramAddr)) == ADDR_W'(1)));

  // R5: status read keeps the upper bits low
  assert_status_upper_R5: assert property (@(posedge clk) disable iff (!rstN)
    (dbOe && cmdSel) |-> (dbOut[7:1] == 7'b0));

endmodule

bind lcdHostFront lcdHostFrontChk #(
  .ADDR_W(ADDR_W),
  .BUSY_CYCLES(BUSY_CYCLES)
) uChk (
  .clk(clk), .rstN(rstN), .busy(busy), .overrun(overrun),
  .ramWe(ramWe), .ramBlinkWe(ramBlinkWe), .ramAddr(ramAddr),
  .dbOe(dbOe), .cmdSel(cmdSel), .dbOut(dbOut)
);

// File: tb/sim_lcdHostFront.sv
`timescale 1ns/1ps
module sim_lcdHostFront;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic serialMode = 1'b0, csN = 1'b1, cmdSel = 1'b0, wrN = 1'b1, rdN = 1'b1;
  logic [7:0] dbIn = '0;
  logic sclk = 1'b1, sdi = 1'b0;
  logic [7:0] dbOut, ramWdata, ramRdata;
  logic dbOe, sdo, busy, overrun, ramWe, ramBlinkWe;
  logic [5:0] ramAddr;

  always #10 clk = ~clk;

  lcdHostFront u0 (
    .clk(clk), .rstN(rstN), .serialMode(serialMode), .csN(csN),
    .cmdSel(cmdSel), .wrN(wrN), .rdN(rdN), .dbIn(dbIn), .dbOut(dbOut),
    .dbOe(dbOe), .sclk(sclk), .sdi(sdi), .sdo(sdo), .busy(busy),
    .overrun(overrun), .ramWe(ramWe), .ramBlinkWe(ramBlinkWe),
    .ramAddr(ramAddr), .ramWdata(ramWdata), .ramRdata(ramRdata)
  );

  // RAM seen by the block
  logic [7:0] mem [64];
  logic       blk [64];
  always @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < 64; i++) begin mem[i] <= 8'h00; blk[i] <= 1'b0; end
    end else begin
      if (ramWe)      mem[ramAddr] <= ramWdata;
      if (ramBlinkWe) blk[ramAddr] <= ramWdata[0];
    end
  end
  assign ramRdata = mem[ramAddr];

  // expected model
  logic [7:0] eMem [64];
  logic       eBlk [64];
  logic [5:0] ePtr;
  logic       eTgt;

  int total = 0, bad = 0;
  bit finished = 0;

  int busyRun = 0, lastRun = 0;
  always @(negedge clk) begin
    if (busy) busyRun++;
    else begin
      if (busyRun != 0) lastRun = busyRun;
      busyRun = 0;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic modelByte(input logic cd, input logic [7:0] b);
    if (!cd) begin
      if (eTgt) eBlk[ePtr] = b[0]; else eMem[ePtr] = b;
      ePtr = ePtr + 6'd1;
    end else if (b[7:6] == 2'b01) ePtr = b[5:0];
    else if (b == 8'h10) begin eMem[ePtr] = 8'h20; eBlk[ePtr] = 1'b0; ePtr = ePtr + 6'd1; end
    else if (b == 8'h11) begin eBlk[ePtr] = 1'b1; ePtr = ePtr + 6'd1; end
    else if (b == 8'h12) eTgt = 1'b0;
    else if (b == 8'h13) eTgt = 1'b1;
  endtask

  task automatic pWrite(input logic cd, input logic [7:0] b);
    @(posedge clk); #1 csN = 1'b0; cmdSel = cd; dbIn = b; wrN = 1'b0;
    repeat (2) @(posedge clk);
    #1 wrN = 1'b1;
    repeat (3) @(posedge clk);
    #1 csN = 1'b1;
  endtask

  task automatic pRead(input logic cd, output logic [7:0] v, output logic oe);
    @(posedge clk); #1 csN = 1'b0; cmdSel = cd; rdN = 1'b0;
    @(negedge clk); v = dbOut; oe = dbOe;
    @(posedge clk); #1 rdN = 1'b1; csN = 1'b1;
  endtask

  task automatic sBit(input logic b);
    @(posedge clk); #1 sclk = 1'b0; sdi = b;
    repeat (3) @(posedge clk);
    #1 sclk = 1'b1;
    repeat (3) @(posedge clk);
  endtask

  task automatic sFrame(input logic cd, input logic [7:0] b, input int nBits);
    @(posedge clk); #1 csN = 1'b0; cmdSel = cd;
    for (int i = 7; i > 7 - nBits; i--) sBit(b[i]);
    @(posedge clk); #1 csN = 1'b1;
  endtask

  task automatic waitIdle();
    @(negedge clk);
    while (busy) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic send(input logic cd, input logic [7:0] b);
    if (serialMode) sFrame(cd, b, 8); else pWrite(cd, b);
    modelByte(cd, b);
    waitIdle();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: run did not end, actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    logic oe;
    logic [5:0] a0;
    void'($urandom(32'd4242));
    for (int i = 0; i < 64; i++) begin eMem[i] = 8'h00; eBlk[i] = 1'b0; end
    ePtr = '0; eTgt = 1'b0;
    repeat (5) @(posedge clk);
    #1 rstN = 1'b1;
    @(negedge clk);
    chk("R13 busy", busy, 0);
    chk("R13 overrun", overrun, 0);
    chk("R13 pointer", ramAddr, 0);
    chk("R13 sdo", sdo, 0);
    chk("R13 dbOe", dbOe, 0);

    // R2 + R6: parallel data write and busy length
    pWrite(1'b0, 8'hA5); modelByte(1'b0, 8'hA5);
    waitIdle();
    chk("R2 data", mem[0], 8'hA5);
    chk("R2 pointer step", ramAddr, 1);
    chk("R6 busy length", lastRun, 10);

    // R8 load + R5 reads
    send(1'b1, 8'h40);
    chk("R8 load", ramAddr, 0);
    pRead(1'b0, v, oe);
    chk("R5 ram read", v, 8'hA5);
    chk("R5 oe", oe, 1);
    pRead(1'b1, v, oe);
    chk("R5 status idle", v, 8'h00);
    pWrite(1'b1, 8'h41); modelByte(1'b1, 8'h41);
    pRead(1'b1, v, oe);
    chk("R5 status busy", v, 8'h01);
    waitIdle();
    chk("R5 oe idle", dbOe, 0);

    // R10 then R9 at address 2
    send(1'b1, 8'h42);
    send(1'b1, 8'h11);
    chk("R10 blink set", blk[2], 1);
    chk("R10 step", ramAddr, 3);
    send(1'b1, 8'h42);
    send(1'b1, 8'h10);
    chk("R9 blank", mem[2], 8'h20);
    chk("R9 blink clear", blk[2], 0);
    chk("R9 step", ramAddr, 3);

    // R11 blink plane target
    send(1'b1, 8'h13);
    send(1'b0, 8'hFF);
    chk("R11 blink data", blk[3], 1);
    chk("R11 display untouched", mem[3], 8'h00);
    chk("R11 step", ramAddr, 4);
    send(1'b1, 8'h12);
    send(1'b1, 8'h3C);
    chk("R11 other cmd no move", ramAddr, 4);

    // R12 wrap
    send(1'b1, 8'h7F);
    send(1'b0, 8'h3C);
    chk("R12 write at top", mem[63], 8'h3C);
    chk("R12 wrap", ramAddr, 0);

    // R7 overrun: second write lands inside busy window
    pWrite(1'b0, 8'h11); modelByte(1'b0, 8'h11);
    pWrite(1'b0, 8'h22);
    waitIdle();
    chk("R7 first kept", mem[0], 8'h11);
    chk("R7 second dropped", mem[1], 8'h00);
    chk("R7 pointer", ramAddr, 1);
    chk("R7 overrun", overrun, 1);

    // serial mode
    #1 serialMode = 1'b1;
    a0 = ramAddr;
    pWrite(1'b0, 8'h99);
    repeat (4) @(negedge clk);
    chk("R1 parallel ignored busy", busy, 0);
    chk("R1 parallel ignored ptr", ramAddr, a0);
    send(1'b1, 8'h45);
    chk("R3 serial load", ramAddr, 5);
    sFrame(1'b0, 8'hFF, 3);
    send(1'b0, 8'h5A);
    chk("R3 partial discarded", mem[5], 8'h5A);
    chk("R3 step", ramAddr, 6);
    // R4: busy on sdo
    sFrame(1'b0, 8'hC3, 8); modelByte(1'b0, 8'hC3);
    @(posedge clk); #1 csN = 1'b0; sclk = 1'b0;
    repeat (3) @(negedge clk);
    chk("R4 sdo busy", sdo, 1);
    #1 sclk = 1'b1;
    repeat (15) @(posedge clk);
    #1 sclk = 1'b0;
    repeat (3) @(negedge clk);
    chk("R4 sdo idle", sdo, 0);
    #1 sclk = 1'b1; repeat (3) @(posedge clk);
    #1 csN = 1'b1;
    waitIdle();
    chk("R3 msb first", mem[6], 8'hC3);

    // R1 reverse: serial ignored in parallel mode
    #1 serialMode = 1'b0;
    a0 = ramAddr;
    sFrame(1'b0, 8'h77, 8);
    repeat (4) @(negedge clk);
    chk("R1 serial ignored busy", busy, 0);
    chk("R1 serial ignored ptr", ramAddr, a0);

    // random mix on both links
    for (int n = 0; n < 80; n++) begin
      logic cd;
      logic [7:0] b;
      cd = 1'($urandom_range(0, 1));
      b  = 8'($urandom_range(0, 255));
      if (cd && $urandom_range(0, 2) == 0) b = 8'h10 + 8'($urandom_range(0, 3));
      #1 serialMode = 1'($urandom_range(0, 1));
      send(cd, b);
    end
    chk("R2 random pointer", ramAddr, ePtr);
    for (int i = 0; i < 64; i++) begin
      chk("R2 random display", mem[i], eMem[i]);
      chk("R11 random blink", blk[i], eBlk[i]);
    end

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule